// File: doc/BRIEF.md
# Power-On Protocol Selector with Answer-to-Reset Transmitter

This block decides, once per power cycle, whether a secure-memory device talks over a synchronous 2-wire bus or over an asynchronous smart-card line. It watches the reset pin on card-clock ticks after power-on. A high level on the first tick selects the synchronous 2-wire mode. A low level selects the asynchronous mode. The choice is held until the block is reset again, and reset here stands for a new power-on.

In synchronous mode the block counts the opening card-clock pulses. It then raises an enable for the command decoder that follows it. In asynchronous mode it waits for the reset pin to rise after it has been low for a minimum number of clock ticks. It then captures a 64-bit answer-to-reset value and sends it as eight framed characters on an open-drain line. Each bit lasts one elementary time unit (ETU) of card-clock ticks. The command protocols that follow either path are handled elsewhere.

Top module: `psel_power_on`

## Requirements
- R1: After reset, mode_sync, mode_async, cmd_enable, io_oe and atr_done are all 0.
- R2: If rst_pin is 1 on the first card_tick after reset, mode_sync becomes 1 and mode_async stays 0.
- R3: If rst_pin is 0 on the first card_tick after reset, mode_async becomes 1 and mode_sync stays 0.
- R4: Once selected, the mode outputs do not change until the next reset, whatever rst_pin does.
- R5: In synchronous mode cmd_enable is 0 after four card_ticks and becomes 1 on the fifth card_tick. The tick that made the selection counts as the first.
- R6: In synchronous mode io_oe is never asserted and atr_done never pulses.
- R7: In asynchronous mode, transmission begins on a card_tick with rst_pin = 1 only if at least 400 consecutive card_ticks with rst_pin = 0 came before it. The selecting tick counts among them. An earlier rise is ignored and restarts the count.
- R8: Each transmitted bit lasts exactly 372 card_ticks. io_oe changes only on a clock edge where card_tick is 1.
- R9: Each character is sent as a start bit of 0, then 8 data bits LSB first, then an even parity bit (the XOR of the data bits), then 2 ETU of idle 1. Character k carries atr_value[8k+7:8k], and k = 0 goes first. atr_value is captured when transmission begins, so later changes do not affect it.
- R10: io_oe is 1 exactly while a 0 bit is on the line, and 0 when idle.
- R11: atr_done pulses for one clock cycle, exactly once, at the end of the last guard time of the eighth character. After that the line stays released, and cmd_enable stays 0 in asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; marks a new power-on |
| card_tick | input | 1 | One-cycle pulse per card-clock rising edge |
| rst_pin | input | 1 | Synchronised level of the card reset pin |
| atr_value | input | 64 | Answer-to-reset content, byte 0 in bits 7:0 |
| mode_sync | output | 1 | Synchronous 2-wire mode selected |
| mode_async | output | 1 | Asynchronous mode selected |
| cmd_enable | output | 1 | Synchronous command decoder may run |
| io_oe | output | 1 | Pull the open-drain IO line low |
| atr_done | output | 1 | One-cycle pulse after the last answer-to-reset character |

## Verification
A wrong mode latch shows up within one clock of the selecting tick as a wrong pair of mode flags, or later as a flag that flips when rst_pin toggles. A wrong low-time counter shows up as IO activity after the early rise, or as silence after the exact 400-tick boundary. Errors in the ETU, bit or byte counters push the line out of phase within one ETU. The bench samples the line at mid-bit and around the first bit boundary, so a phase error appears at the first affected bit. A wrong end-of-frame decode shows up as a missing or repeated done pulse about 35,712 ticks after the start.

// File: rtl/psel_pkg.sv
package psel_pkg;
  typedef enum logic [2:0] {
    PS_SAMPLE,
    PS_SYNC_WARM,
    PS_SYNC_READY,
    PS_ASYNC_WAIT,
    PS_ASYNC_TX,
    PS_ASYNC_DONE
  } psel_state_e;

  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_HEAD = 2; // start bit plus parity bit
endpackage

// File: rtl/psel_sat_cnt.sv
module psel_sat_cnt #(
  parameter int unsigned LIMIT = 400,
  localparam int unsigned W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic full
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clr) count_q <= '0;
    else if (inc && !full) count_q <= count_q + 1'b1;
  end

  assign full = (count_q == W'(LIMIT));
endmodule

// File: rtl/psel_atr_tx.sv
module psel_atr_tx
  import psel_pkg::*;
#(
  parameter int unsigned ETU_TICKS = 372,
  parameter int unsigned GUARD_ETU = 2,
  parameter int unsigned ATR_BYTES = 8,
  localparam int unsigned ATR_W      = ATR_BYTES * DATA_BITS,
  localparam int unsigned FRAME_BITS = DATA_BITS + FRAME_HEAD + GUARD_ETU,
  localparam int unsigned ETU_W      = $clog2(ETU_TICKS),
  localparam int unsigned BIT_W      = $clog2(FRAME_BITS),
  localparam int unsigned BYTE_W     = (ATR_BYTES > 1) ? $clog2(ATR_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [ATR_W-1:0] atr_in,
  output logic             io_oe,
  output logic             done
);
  localparam logic [ETU_W-1:0]  ETU_LAST  = ETU_W'(ETU_TICKS - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(ATR_BYTES - 1);
  localparam logic [BIT_W-1:0]  PAR_POS   = BIT_W'(DATA_BITS + 1);

  logic              active_q, active_d;
  logic [ETU_W-1:0]  etu_q, etu_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [ATR_W-1:0]  data_q, data_d;
  logic [DATA_BITS-1:0] cur_byte, shifted;
  logic line_d, frame_end;

  always_comb begin
    active_d = active_q;
    etu_d    = etu_q;
    bit_d    = bit_q;
    byte_d   = byte_q;
    data_d   = data_q;
    if (start && !active_q) begin
      active_d = 1'b1;
      etu_d    = '0;
      bit_d    = '0;
      byte_d   = '0;
      data_d   = atr_in;
    end else if (active_q && tick) begin
      if (etu_q == ETU_LAST) begin
        etu_d = '0;
        if (bit_q == BIT_LAST) begin
          bit_d = '0;
          if (byte_q == BYTE_LAST) active_d = 1'b0;
          else byte_d = byte_q + 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end else begin
        etu_d = etu_q + 1'b1;
      end
    end
  end

  assign frame_end = active_q && tick && (etu_q == ETU_LAST) &&
                     (bit_q == BIT_LAST) && (byte_q == BYTE_LAST);

  // Line level for the next state: start, data LSB first, parity, guard.
  always_comb begin
    cur_byte = data_d[{byte_d, 3'b000} +: DATA_BITS];
    shifted  = cur_byte >> (bit_d - 1'b1);
    if (!active_d)              line_d = 1'b1;
    else if (bit_d == '0)       line_d = 1'b0;
    else if (bit_d < PAR_POS)   line_d = shifted[0];
    else if (bit_d == PAR_POS)  line_d = ^cur_byte;
    else                        line_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      etu_q    <= '0;
      bit_q    <= '0;
      byte_q   <= '0;
      data_q   <= '0;
      io_oe    <= 1'b0;
      done     <= 1'b0;
    end else begin
      active_q <= active_d;
      etu_q    <= etu_d;
      bit_q    <= bit_d;
      byte_q   <= byte_d;
      data_q   <= data_d;
      io_oe    <= !line_d;
      done     <= frame_end;
    end
  end
endmodule

// File: rtl/psel_power_on.sv
module psel_power_on
  import psel_pkg::*;
#(
  parameter int unsigned ETU_TICKS   = 372,
  parameter int unsigned WAIT_TICKS  = 400,
  parameter int unsigned SYNC_PULSES = 5,
  parameter int unsigned GUARD_ETU   = 2,
  parameter int unsigned ATR_BYTES   = 8,
  localparam int unsigned ATR_W = ATR_BYTES * DATA_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             card_tick,
  input  logic             rst_pin,
  input  logic [ATR_W-1:0] atr_value,
  output logic             mode_sync,
  output logic             mode_async,
  output logic             cmd_enable,
  output logic             io_oe,
  output logic             atr_done
);
  psel_state_e state_q;
  logic low_inc, low_clr, low_full;
  logic pulse_inc, pulse_full;
  logic tx_start;

  assign low_inc   = card_tick && !rst_pin &&
                     (state_q == PS_SAMPLE || state_q == PS_ASYNC_WAIT);
  assign low_clr   = (state_q == PS_ASYNC_WAIT) && card_tick && rst_pin && !low_full;
  assign tx_start  = (state_q == PS_ASYNC_WAIT) && card_tick && rst_pin && low_full;
  assign pulse_inc = card_tick &&
                     ((state_q == PS_SAMPLE && rst_pin) || state_q == PS_SYNC_WARM);

  psel_sat_cnt #(.LIMIT(WAIT_TICKS)) i_low_cnt (
    .clk(clk), .rst(rst), .clr(low_clr), .inc(low_inc), .full(low_full)
  );

  psel_sat_cnt #(.LIMIT(SYNC_PULSES - 1)) i_pulse_cnt (
    .clk(clk), .rst(rst), .clr(1'b0), .inc(pulse_inc), .full(pulse_full)
  );

  psel_atr_tx #(
    .ETU_TICKS(ETU_TICKS), .GUARD_ETU(GUARD_ETU), .ATR_BYTES(ATR_BYTES)
  ) i_atr_tx (
    .clk(clk), .rst(rst), .tick(card_tick), .start(tx_start),
    .atr_in(atr_value), .io_oe(io_oe), .done(atr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PS_SAMPLE;
      mode_sync  <= 1'b0;
      mode_async <= 1'b0;
      cmd_enable <= 1'b0;
    end else begin
      unique case (state_q)
        PS_SAMPLE: if (card_tick) begin
          if (rst_pin) begin
            mode_sync <= 1'b1;
            state_q   <= PS_SYNC_WARM;
          end else begin
            mode_async <= 1'b1;
            state_q    <= PS_ASYNC_WAIT;
          end
        end
        PS_SYNC_WARM: if (card_tick && pulse_full) begin
          cmd_enable <= 1'b1;
          state_q    <= PS_SYNC_READY;
        end
        PS_ASYNC_WAIT: if (tx_start) state_q <= PS_ASYNC_TX;
        PS_ASYNC_TX:   if (atr_done) state_q <= PS_ASYNC_DONE;
        PS_SYNC_READY, PS_ASYNC_DONE: state_q <= state_q;
        default: state_q <= PS_SAMPLE;
      endcase
    end
  end
endmodule

// File: rtl/psel_power_on_chk.sv
module psel_power_on_chk (
  input logic clk,
  input logic rst,
  input logic card_tick,
  input logic rst_pin,
  input logic mode_sync,
  input logic mode_async,
  input logic cmd_enable,
  input logic io_oe,
  input logic atr_done
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!mode_sync && !mode_async && !cmd_enable && !io_oe && !atr_done));

  assert_pick_sync_R2: assert property (@(posedge clk) disable iff (rst)
    (!mode_sync && !mode_async && card_tick && rst_pin) |=> (mode_sync && !mode_async));

  assert_pick_async_R3: assert property (@(posedge clk) disable iff (rst)
    (!mode_sync && !mode_async && card_tick && !rst_pin) |=> (mode_async && !mode_sync));

  assert_modes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(mode_sync && mode_async));

  assert_sync_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    mode_sync |=> mode_sync);

  assert_async_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    mode_async |=> mode_async);

  assert_cmd_sync_only_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_enable |-> mode_sync);

  assert_cmd_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_enable |=> cmd_enable);

  assert_sync_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    mode_sync |-> (!io_oe && !atr_done));

  assert_oe_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(io_oe) |-> $past(card_tick));

  assert_oe_async_only_R10: assert property (@(posedge clk) disable iff (rst)
    io_oe |-> mode_async);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    atr_done |=> !atr_done);
endmodule

bind psel_power_on psel_power_on_chk i_psel_power_on_chk (
  .clk(clk), .rst(rst), .card_tick(card_tick), .rst_pin(rst_pin),
  .mode_sync(mode_sync), .mode_async(mode_async), .cmd_enable(cmd_enable),
  .io_oe(io_oe), .atr_done(atr_done)
);

// File: tb/test_psel_power_on.sv
`timescale 1ns/1ps
module test_psel_power_on;
  localparam int ETU = 372;
  localparam int NBITS = 96;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, card_tick, rst_pin;
  logic [63:0] atr_value;
  logic mode_sync, mode_async, cmd_enable, io_oe, atr_done;

  psel_power_on i_psel_power_on (
    .clk(clk), .rst(rst), .card_tick(card_tick), .rst_pin(rst_pin),
    .atr_value(atr_value), .mode_sync(mode_sync), .mode_async(mode_async),
    .cmd_enable(cmd_enable), .io_oe(io_oe), .atr_done(atr_done)
  );

  int n_checks = 0;
  int n_fail = 0;
  int gap_max = 0;
  int done_total = 0;
  int oe_total = 0;

  always @(posedge clk) begin
    if (atr_done) done_total++;
    if (io_oe) oe_total++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, gap_max)) @(negedge clk);
      card_tick = 1'b1;
      @(negedge clk);
      card_tick = 1'b0;
    end
  endtask

  task automatic power_on();
    rst = 1'b1;
    card_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Expected line level for stream bit j (12 bits per character).
  function automatic logic exp_line(input logic [63:0] atr, input int j);
    logic [7:0] d;
    int k;
    d = atr[(j / 12) * 8 +: 8];
    k = j % 12;
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k - 1];
    if (k == 9) return ^d;
    return 1'b1;
  endfunction

  // Called right after the start tick (tick index 0).
  task automatic stream_check(input logic [63:0] atr);
    int t = 0;
    int d0 = done_total;
    for (int j = 0; j < NBITS; j++) begin
      run_ticks(j * ETU + ETU / 2 - t);
      t = j * ETU + ETU / 2;
      check("R9 R10 frame bit", io_oe, !exp_line(atr, j));
      if (j == 0) begin
        run_ticks(ETU - 2 - t); t = ETU - 2;
        check("R8 end of start bit", io_oe, !exp_line(atr, 0));
        run_ticks(3); t = ETU + 1;
        check("R8 first data bit", io_oe, !exp_line(atr, 1));
      end
      if (j == 5) atr_value = ~atr_value; // R9: capture at start
    end
    run_ticks(NBITS * ETU - t + 3);
    check("R11 one done pulse", done_total - d0, 1);
    check("R11 line released", io_oe, 0);
    check("R11 no cmd enable", cmd_enable, 0);
  endtask

  initial begin
    int oe0, d0;
    logic [63:0] atr;
    void'($urandom(32'h1c0ffee));
    rst = 1'b1; rst_pin = 1'b1; card_tick = 1'b0; atr_value = '0;
    power_on();
    check("R1 reset outputs", {mode_sync, mode_async, cmd_enable, io_oe, atr_done}, 0);

    // synchronous selection
    rst_pin = 1'b1;
    run_ticks(4);
    check("R2 sync selected", {mode_sync, mode_async}, 2'b10);
    check("R5 no enable after 4 ticks", cmd_enable, 0);
    run_ticks(1);
    check("R5 enable on 5th tick", cmd_enable, 1);
    oe0 = oe_total; d0 = done_total;
    for (int i = 0; i < 300; i++) begin
      rst_pin = 1'($urandom);
      run_ticks(2);
    end
    check("R6 no io in sync", oe_total - oe0, 0);
    check("R6 no done in sync", done_total - d0, 0);
    check("R4 sync kept", {mode_sync, mode_async, cmd_enable}, 3'b101);

    // asynchronous, directed, with early rises
    power_on();
    atr = 64'h3B9A_00FF_5C21_E781;
    atr_value = atr;
    rst_pin = 1'b0;
    run_ticks(200);
    check("R3 async selected", {mode_sync, mode_async}, 2'b01);
    oe0 = oe_total;
    rst_pin = 1'b1; run_ticks(10);
    rst_pin = 1'b0; run_ticks(399);
    rst_pin = 1'b1; run_ticks(20);
    check("R7 early rises ignored", oe_total - oe0, 0);
    rst_pin = 1'b0; run_ticks(400);
    rst_pin = 1'b1; run_ticks(1);
    check("R7 start after 400 low", io_oe, 1);
    stream_check(atr);
    oe0 = oe_total; d0 = done_total;
    rst_pin = 1'b0; run_ticks(450);
    rst_pin = 1'b1; run_ticks(50);
    check("R4 async kept", {mode_sync, mode_async}, 2'b01);
    check("R11 no resend", (oe_total - oe0) + (done_total - d0), 0);

    // asynchronous, random content and tick spacing, exact boundary
    power_on();
    gap_max = 1;
    atr = {$urandom, $urandom};
    atr_value = atr;
    rst_pin = 1'b0;
    run_ticks(399);
    check("R3 async selected random", {mode_sync, mode_async}, 2'b01);
    check("R7 idle before rise", io_oe, 0);
    run_ticks(1);
    rst_pin = 1'b1; run_ticks(1);
    check("R7 start at exactly 400", io_oe, 1);
    stream_check(atr);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule